// File: doc/BRIEF.md
# SPI Status and Interrupt Flag Unit

This block keeps the status word and the interrupt-enable mask of an SPI peripheral and drives its single interrupt line. The shift engine stays outside. It reports events to this unit through single-cycle pulses and level signals: received byte ready, transmit holding data taken by the shifter, receive overrun, transmit underrun, the active state of every select line, stall, frame in progress and transmitter idle. Software reaches the unit through a simple register strobe interface. Reading the receive data location and writing the transmit data location are seen here only as strobes. Their only effect in this unit is on the matching ready flags.

The status word holds four kinds of bit. Two flags clear on data access. Four flags are sticky and cleared by writing 1. Two bits follow live conditions. One command bit sets under software control and clears itself. That command bit is tracked by a two-state machine. In `ET_IDLE`, writing 1 to status bit 7 takes the transition *request* to `ET_PEND`. In `ET_PEND`, a cycle with `tx_idle` high takes the transition *complete* back to `ET_IDLE`. Otherwise the machine holds its state. The `end_req` output is high in `ET_PEND`.

Top module: `spi_stat_irq`

## Requirements
- R1: Status bit 0 (receive ready) is 0 after reset. It is 1 in the cycle after `ev_rx_valid`. A read strobe at address 3 clears it in the next cycle, except when `ev_rx_valid` is high in the same cycle; the set then wins.
- R2: Status bit 1 (transmit ready) is 1 after reset. A write strobe at address 4 clears it. `ev_tx_load` sets it, and a set wins over a simultaneous write.
- R3: Status bits 2 (overrun) and 3 (underrun) set on `ev_overrun` and `ev_underrun` and stay set. Writing 1 to that bit at address 0 clears it, except when the event arrives in the same cycle.
- R4: Status bit 4 sets when any select line goes from inactive to active. Status bit 5 sets when any select line goes from active to inactive. Both are sticky and are cleared by writing 1 at address 0. An edge in the same cycle as the clear wins.
- R5: Status bit 6 equals `stall_in`. Status bit 8 (master idle) is 1 exactly when transmit ready is 1 and `frame_busy` is 0, so after reset it reads 1 while no frame runs.
- R6: Writing 1 to bit 7 at address 0 sets the end-transfer request. The request shows on status bit 7 and on `end_req` from the next cycle onward. It clears in the cycle after a cycle in `ET_PEND` with `tx_idle` high. Writing 0 to bit 7 has no effect.
- R7: The enable mask has 6 bits and resets to 0. A write at address 1 sets the bits that are 1 in the write data. A write at address 2 clears the bits that are 1. A read at either address returns the mask in bits 5:0.
- R8: `irq` is high exactly when some status bit in 5:0 is 1 and its enable bit is also 1.
- R9: Bits 31:9 of a status read, bits 31:6 of an enable read and every bit of a read at any other address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address (0 status, 1 enable set, 2 enable clear, 3 rx data, 4 tx data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ev_rx_valid | input | 1 | Pulse: a received word is ready |
| ev_tx_load | input | 1 | Pulse: transmit holding data moved into the shifter |
| ev_overrun | input | 1 | Pulse: receive overrun |
| ev_underrun | input | 1 | Pulse: transmit underrun |
| sel_active | input | 4 | Per select line, 1 when that line is in its active state |
| stall_in | input | 1 | Engine is stalled |
| frame_busy | input | 1 | A frame is in progress |
| tx_idle | input | 1 | Transmitter has gone idle |
| end_req | output | 1 | End-transfer request to the engine |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `sel_active` is already polarity-corrected and is inactive (all zero) when reset is released. They assume event pulses last one cycle each and are sampled as given, with no handshake. They also assume that a read and a write never target the same data location in the same cycle. The stimulus drives each input from a fixed-seed random source and issues at most one bus operation per cycle. It holds the select lines at zero through reset. Directed cycles force each event to coincide with its own clear so that the priority rules are exercised.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_ENSET = 3'd1;
    localparam logic [ADDR_W-1:0] A_ENCLR = 3'd2;
    localparam logic [ADDR_W-1:0] A_RXACC = 3'd3;
    localparam logic [ADDR_W-1:0] A_TXACC = 3'd4;

    localparam int B_RX    = 0;
    localparam int B_TX    = 1;
    localparam int B_OVR   = 2;
    localparam int B_STALL = 6;
    localparam int B_ETR   = 7;
    localparam int B_IDLE  = 8;
    localparam int N_STK   = 4;
    localparam int N_IRQ   = 6;
    localparam int STAT_W  = 9;

    typedef enum logic {ET_IDLE, ET_PEND} et_state_t;
endpackage

// File: rtl/spi_sel_edge.sv
module spi_sel_edge #(
    parameter int NSEL = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSEL-1:0] sel_active,
    output logic            any_rise,
    output logic            any_fall
);
    logic [NSEL-1:0] sel_q;
    logic [NSEL-1:0] rise_v;
    logic [NSEL-1:0] fall_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_active;
    end

    for (genvar i = 0; i < NSEL; i++) begin : g_line
        assign rise_v[i] = sel_active[i] & ~sel_q[i];
        assign fall_v[i] = ~sel_active[i] & sel_q[i];
    end

    assign any_rise = |rise_v;
    assign any_fall = |fall_v;
endmodule

// File: rtl/spi_endxfer_fsm.sv
module spi_endxfer_fsm
    import spi_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic tx_idle,
    output logic pending
);
    et_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ET_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ET_IDLE: if (req_set) state_d = ET_PEND;
            ET_PEND: if (tx_idle) state_d = ET_IDLE;
            default: state_d = ET_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == ET_PEND);
    end

    AST_ETR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ET_PEND && tx_idle) |=> (state_q == ET_IDLE)); // R6
    AST_ETR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ET_IDLE && req_set) |=> pending); // R6
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
    parameter int NB = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic [NB-1:0] wbits,
    input  logic [NB-1:0] flags,
    output logic [NB-1:0] en,
    output logic          irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en <= '0;
        else if (set_we) en <= en | wbits;
        else if (clr_we) en <= en & ~wbits;
    end

    assign irq = |(flags & en);

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en & $past(wbits)) == $past(wbits))); // R7
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((en & $past(wbits)) == '0)); // R7
endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq
    import spi_flag_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NSEL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              ev_rx_valid,
    input  logic              ev_tx_load,
    input  logic              ev_overrun,
    input  logic              ev_underrun,
    input  logic [NSEL-1:0]   sel_active,
    input  logic              stall_in,
    input  logic              frame_busy,
    input  logic              tx_idle,
    output logic              end_req,
    output logic              irq
);
    logic              rx_rdy, tx_rdy;
    logic              stat_wr, rx_acc, tx_acc;
    logic              any_rise, any_fall;
    logic [N_STK-1:0]  stk_ev, stk_clr, stk_q;
    logic [N_IRQ-1:0]  en_mask;
    logic [STAT_W-1:0] stat_word;
    logic              unused_wbits;

    assign stat_wr      = bus_wr && (bus_addr == A_STAT);
    assign rx_acc       = bus_rd && (bus_addr == A_RXACC);
    assign tx_acc       = bus_wr && (bus_addr == A_TXACC);
    assign unused_wbits = ^bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           rx_rdy <= 1'b0;
        else if (ev_rx_valid) rx_rdy <= 1'b1;
        else if (rx_acc)      rx_rdy <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          tx_rdy <= 1'b1;
        else if (ev_tx_load) tx_rdy <= 1'b1;
        else if (tx_acc)     tx_rdy <= 1'b0;
    end

    spi_sel_edge #(.NSEL(NSEL)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_active (sel_active),
        .any_rise   (any_rise),
        .any_fall   (any_fall)
    );

    assign stk_ev = {any_fall, any_rise, ev_underrun, ev_overrun};

    for (genvar i = 0; i < N_STK; i++) begin : g_stk
        assign stk_clr[i] = stat_wr & bus_wdata[B_OVR+i];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          stk_q[i] <= 1'b0;
            else if (stk_ev[i])  stk_q[i] <= 1'b1;
            else if (stk_clr[i]) stk_q[i] <= 1'b0;
        end
    end

    spi_endxfer_fsm u_etr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_set (stat_wr & bus_wdata[B_ETR]),
        .tx_idle (tx_idle),
        .pending (end_req)
    );

    assign stat_word[B_RX]                 = rx_rdy;
    assign stat_word[B_TX]                 = tx_rdy;
    assign stat_word[B_OVR+N_STK-1:B_OVR]  = stk_q;
    assign stat_word[B_STALL]              = stall_in;
    assign stat_word[B_ETR]                = end_req;
    assign stat_word[B_IDLE]               = tx_rdy & ~frame_busy;

    spi_irq_mask #(.NB(N_IRQ)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (bus_wr && (bus_addr == A_ENSET)),
        .clr_we (bus_wr && (bus_addr == A_ENCLR)),
        .wbits  (bus_wdata[N_IRQ-1:0]),
        .flags  (stat_word[N_IRQ-1:0]),
        .en     (en_mask),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STAT:           bus_rdata[STAT_W-1:0] = stat_word;
            A_ENSET, A_ENCLR: bus_rdata[N_IRQ-1:0]  = en_mask;
            default:          bus_rdata = '0;
        endcase
    end

    AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_valid |=> rx_rdy); // R1
    AST_RX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_acc && !ev_rx_valid) |=> !rx_rdy); // R1
    AST_TX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_load |=> tx_rdy); // R2
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_q[0] && !(stat_wr && bus_wdata[B_OVR])) |=> stk_q[0]); // R3
    AST_SSA_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        any_rise |=> stat_word[4]); // R4
    AST_SSD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        any_fall |=> stat_word[5]); // R4
    AST_IDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_busy |-> !bus_rdata[B_IDLE]); // R5
    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |-> !irq); // R8
endmodule

// File: tb/spi_stat_irq_bench.sv
`timescale 1ns/1ps
module spi_stat_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        ev_rx_valid, ev_tx_load, ev_overrun, ev_underrun;
    logic [3:0]  sel_active;
    logic        stall_in, frame_busy, tx_idle;
    logic        end_req, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    bit m_rx, m_tx, m_ovr, m_und, m_ssa, m_ssd, m_et;
    bit [5:0] m_en;
    bit [3:0] m_sel;

    always #2.5 clk = ~clk;

    spi_stat_irq u_spi_stat_irq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rx_valid(ev_rx_valid), .ev_tx_load(ev_tx_load),
        .ev_overrun(ev_overrun), .ev_underrun(ev_underrun),
        .sel_active(sel_active), .stall_in(stall_in), .frame_busy(frame_busy),
        .tx_idle(tx_idle), .end_req(end_req), .irq(irq)
    );

    function automatic bit [31:0] exp_status();
        bit [31:0] s = '0;
        s[0] = m_rx; s[1] = m_tx; s[2] = m_ovr; s[3] = m_und;
        s[4] = m_ssa; s[5] = m_ssd; s[6] = stall_in; s[7] = m_et;
        s[8] = m_tx & ~frame_busy;
        return s;
    endfunction

    function automatic bit exp_irq();
        bit [31:0] s = exp_status();
        return |(s[5:0] & m_en);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_step();
        bit stw = bus_wr && bus_addr == 3'd0;
        bit rise = |(sel_active & ~m_sel);
        bit fall = |(~sel_active & m_sel);
        if (ev_rx_valid) m_rx = 1; else if (bus_rd && bus_addr == 3'd3) m_rx = 0;
        if (ev_tx_load)  m_tx = 1; else if (bus_wr && bus_addr == 3'd4) m_tx = 0;
        if (ev_overrun)  m_ovr = 1; else if (stw && bus_wdata[2]) m_ovr = 0;
        if (ev_underrun) m_und = 1; else if (stw && bus_wdata[3]) m_und = 0;
        if (rise) m_ssa = 1; else if (stw && bus_wdata[4]) m_ssa = 0;
        if (fall) m_ssd = 1; else if (stw && bus_wdata[5]) m_ssd = 0;
        if (!m_et) begin if (stw && bus_wdata[7]) m_et = 1; end
        else if (tx_idle) m_et = 0;
        if (bus_wr && bus_addr == 3'd1) m_en = m_en | bus_wdata[5:0];
        else if (bus_wr && bus_addr == 3'd2) m_en = m_en & ~bus_wdata[5:0];
        m_sel = sel_active;
    endtask

    task automatic check_all();
        bit [31:0] e;
        bus_wr = 0; bus_rd = 0; bus_addr = 3'd0; bus_wdata = '0;
        #0.5;
        e = exp_status();
        check("R1 rx_ready",   {31'b0, bus_rdata[0]}, {31'b0, e[0]});
        check("R2 tx_ready",   {31'b0, bus_rdata[1]}, {31'b0, e[1]});
        check("R3 ovr_und",    {30'b0, bus_rdata[3:2]}, {30'b0, e[3:2]});
        check("R4 sel_edges",  {30'b0, bus_rdata[5:4]}, {30'b0, e[5:4]});
        check("R5 stall_idle", {30'b0, bus_rdata[8], bus_rdata[6]}, {30'b0, e[8], e[6]});
        check("R6 end_xfer",   {30'b0, bus_rdata[7], end_req}, {30'b0, e[7], e[7]});
        check("R8 irq",        {31'b0, irq}, {31'b0, exp_irq()});
        check("R9 stat_rsvd",  {23'b0, bus_rdata[31:9]}, 32'd0);
        bus_addr = 3'd1; #0.2;
        check("R7 enable",     bus_rdata, {26'b0, m_en});
        bus_addr = 3'd2; #0.2;
        check("R7 enable_rd2", bus_rdata, {26'b0, m_en});
        bus_addr = 3'd6; #0.2;
        check("R9 unmapped",   bus_rdata, 32'd0);
        bus_addr = 3'd0;
    endtask

    // inputs set before call; one clock edge, model update, checks
    task automatic tick();
        @(posedge clk);
        model_step();
        #0.5;
        ev_rx_valid = 0; ev_tx_load = 0; ev_overrun = 0; ev_underrun = 0;
        check_all();
        @(negedge clk);
    endtask

    task automatic bus(bit wr, bit rd, bit [2:0] a, bit [31:0] d);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        ev_rx_valid = 0; ev_tx_load = 0; ev_overrun = 0; ev_underrun = 0;
        sel_active = 0; stall_in = 0; frame_busy = 0; tx_idle = 0;
        m_rx = 0; m_tx = 1; m_ovr = 0; m_und = 0; m_ssa = 0; m_ssd = 0;
        m_et = 0; m_en = 0; m_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all();                       // reset state, R2 and R5 read 1s
        @(negedge clk);

        // R1: set, set-vs-read priority, read clear
        ev_rx_valid = 1; tick();
        ev_rx_valid = 1; bus(1'b0, 1'b1, 3'd3, 0); tick();
        bus(1'b0, 1'b1, 3'd3, 0); tick();
        // R2: write clears, load wins over write
        bus(1'b1, 1'b0, 3'd4, 0); frame_busy = 1; tick();
        ev_tx_load = 1; bus(1'b1, 1'b0, 3'd4, 0); tick();
        frame_busy = 0;
        // R3: event wins over clear, then clear
        ev_overrun = 1; ev_underrun = 1; tick();
        ev_overrun = 1; bus(1'b1, 1'b0, 3'd0, 32'h0C); tick();
        bus(1'b1, 1'b0, 3'd0, 32'h0C); tick();
        // R4: select edges on different lines
        sel_active = 4'b0001; tick();
        sel_active = 4'b0011; tick();
        sel_active = 4'b0010; bus(1'b1, 1'b0, 3'd0, 32'h10); tick();
        sel_active = 4'b0000; bus(1'b1, 1'b0, 3'd0, 32'h30); tick();
        bus(1'b1, 1'b0, 3'd0, 32'h30); tick();
        // R6: write 0 no effect, set, hold, complete
        bus(1'b1, 1'b0, 3'd0, 32'h7F & ~32'h3C); tick();
        bus(1'b1, 1'b0, 3'd0, 32'h80); tick();
        stall_in = 1; tick();
        tx_idle = 1; tick();
        tx_idle = 0; stall_in = 0; tick();
        // R7 / R8: enable set and clear drive irq
        bus(1'b1, 1'b0, 3'd1, 32'hFFFF_FFC1); tick();
        ev_rx_valid = 1; tick();
        bus(1'b1, 1'b0, 3'd2, 32'h01); tick();
        bus(1'b1, 1'b0, 3'd0, 32'hFFFF_FFFF); tick();

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            bit [2:0] op = 3'($urandom_range(0, 5));
            ev_rx_valid = ($urandom_range(0, 7) == 0);
            ev_tx_load  = ($urandom_range(0, 7) == 0);
            ev_overrun  = ($urandom_range(0, 11) == 0);
            ev_underrun = ($urandom_range(0, 11) == 0);
            if ($urandom_range(0, 3) == 0) sel_active = 4'($urandom());
            stall_in   = ($urandom_range(0, 5) == 0);
            frame_busy = ($urandom_range(0, 2) == 0);
            tx_idle    = ($urandom_range(0, 3) == 0);
            if (op < 2)       bus(1'b1, 1'b0, 3'($urandom_range(0, 7)), $urandom());
            else if (op < 4)  bus(1'b0, 1'b1, 3'($urandom_range(0, 7)), 0);
            else              bus(1'b0, 1'b0, 3'd0, 0);
            tick();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule